// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block keeps a small table of protection regions and, for every access presented to it, returns a three-way verdict. The verdict is one of: no region touches the access, the access is fully permitted, or the access is denied. Each region has two registers. One is an address register that holds a byte address divided by four. The other is an 8-bit configuration byte, which gives a matching mode and read/write/execute permissions. Software loads both through a simple register port. The configuration bytes are packed several to a register word, and the number of bytes per word depends on the register width.

An access is given as a start byte address, a byte length and the set of rights it needs. Every region decodes its byte range in parallel. The region's mode selects how: a range bounded by the previous region's address, a fixed four-byte slot, or a naturally aligned power-of-two block. The regions that overlap the access are then walked in ascending order. Each permitting region adds its overlapping byte count to a running total. The walk stops taking regions into account once the total reaches the access length.

The verdict is combinational from the access inputs and the register state. A register write shows up in the verdict from the cycle after the write.

Top module: `pmp_checker`

## Requirements
- R1: After reset, every address register and every configuration byte reads back zero, and every access gets the verdict "none" (code 0).
- R2: With a 32-bit register width, the configuration byte of region k sits at bits 8*(k%4)+7 down to 8*(k%4) of configuration word k/4. A single write to a configuration word updates all four of its bytes at once, and a read returns them in the same layout.
- R3: With a 64-bit register width, eight bytes are packed per word. Regions 0–7 use word number 0 and regions 8–15 use word number 2. An odd word number reads as zero, and writes to it are dropped.
- R4: An address register keeps all register-width bits written to it and returns them on a read.
- R5: Configuration byte bits 4:3 give the mode (0 off, 1 range-from-previous, 2 four-byte, 3 power-of-two), and bits 2:0 give the R, W and X permissions. A region whose mode is off never matches, whatever its permissions and address.
- R6: In range-from-previous mode, a region covers [4*A(k-1), 4*A(k)), where A is the address register and region 0 uses a lower bound of 0. The previous region's address is used even when that region is off. A region whose upper bound is not above its lower bound covers nothing.
- R7: In four-byte mode, a region covers [4*A, 4*A+4).
- R8: In power-of-two mode, let t be the number of consecutive ones at the bottom of A, capped at XLEN-1. The size is 2^(t+3). The base is A with those t bits cleared, times four, kept modulo 2^XLEN. An all-ones register therefore covers the whole byte address space.
- R9: A region overlaps the access when the two half-open byte ranges share at least one byte. The upper end of a region is excluded.
- R10: If any region taken into account overlaps the access but lacks one of the requested rights, the verdict is "deny" (code 2).
- R11: If the overlapped byte total is zero, the verdict is "none" (code 0). If the total reaches the access length, the verdict is "full" (code 1). Otherwise the verdict is "deny" (code 2). A zero-length access always gets "none".
- R12: Regions are taken in ascending index order. Once the running total reaches the access length, later regions are ignored, including ones that would deny.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_is_addr | input | 1 | 1 selects an address register, 0 selects a configuration word |
| csr_num | input | IW | Register number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the selected register |
| acc_addr | input | XLEN | Access start byte address |
| acc_len | input | XLEN | Access length in bytes |
| acc_perm | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| acc_verdict | output | 2 | 0 none, 1 full, 2 deny |

## Verification
The bench loads a region set with several deliberate overlaps:
- a read-only four-byte slot,
- a read-write range sharing its base,
- an execute-only power-of-two block covering both,
- an inverted range-from-previous region,
- an off region that still has permissions set.

It then sweeps unaligned addresses, several lengths and every rights combination across all of them. The overlaps expose these defects:
- A design that counted an inverted range as wrapping around would report coverage where there is none.
- A design that let an off region match would do the same.
- A design that kept walking after full coverage would deny reads that the four-byte slot already satisfied.
- A design that treated region ends as inclusive would accept or deny one byte too many at each boundary.

The power-of-two decode is probed at the edges of a 4 KiB block and with an all-ones register. A design with a mis-sized mask would show up there, as would one that dropped the modulo wrap of the base. The 64-bit packing is checked on a second instance, including that odd word numbers are ignored.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

   localparam int CFG_W  = 8;
   localparam int PERM_W = 3;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      VERD_NONE = 2'd0,
      VERD_FULL = 2'd1,
      VERD_DENY = 2'd2
   } verdict_e;

   function automatic amode_e cfg_mode(input logic [CFG_W-1:0] c);
      return amode_e'(c[4:3]);
   endfunction

   function automatic logic [PERM_W-1:0] cfg_perm(input logic [CFG_W-1:0] c);
      return c[PERM_W-1:0];
   endfunction

endpackage

// File: rtl/pmpc_csr_file.sv
module pmpc_csr_file
   import pmpc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 16,
   localparam int IW = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             is_addr,
   input  logic [IW-1:0]    num,
   input  logic [XLEN-1:0]  wdata,
   output logic [XLEN-1:0]  rdata,
   output logic [CFG_W-1:0] cfg_o  [NREG],
   output logic [XLEN-1:0]  addr_o [NREG]
);
   localparam int PER   = XLEN / CFG_W;
   localparam int NWORD = NREG / PER;

   logic [IW-1:0] word_idx;
   logic          word_ok;
   logic [NWORD-1:0][XLEN-1:0] word_v;

   // word numbering depends on register width
   generate
      if (XLEN == 32) begin : g_narrow
         assign word_idx = num;
         assign word_ok  = int'(num) < NWORD;
      end else begin : g_wide
         assign word_idx = {1'b0, num[IW-1:1]};
         assign word_ok  = !num[0] && (int'(num) / 2) < NWORD;
      end
   endgenerate

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_slot
         logic sel_addr, sel_cfg;
         assign sel_addr = we && is_addr && (num == IW'(r));
         assign sel_cfg  = we && !is_addr && word_ok && (word_idx == IW'(r / PER));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_o[r]  <= '0;
               addr_o[r] <= '0;
            end else begin
               if (sel_cfg)  cfg_o[r]  <= wdata[CFG_W*(r%PER) +: CFG_W];
               if (sel_addr) addr_o[r] <= wdata;
            end
         end

         assign word_v[r/PER][CFG_W*(r%PER) +: CFG_W] = cfg_o[r];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (is_addr) begin
         rdata = addr_o[num];
      end else begin
         for (int w = 0; w < NWORD; w++) begin
            if (word_ok && word_idx == IW'(w)) rdata = word_v[w];
         end
      end
   end

endmodule

// File: rtl/pmpc_region_decode.sv
module pmpc_region_decode
   import pmpc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int EW   = XLEN + 3
) (
   input  logic [CFG_W-1:0]  cfg,
   input  logic [XLEN-1:0]   cur,
   input  logic [XLEN-1:0]   below,
   output logic              en,
   output logic [EW-1:0]     lo,
   output logic [EW-1:0]     hi,
   output logic [PERM_W-1:0] perm
);
   logic [XLEN-1:0] run;
   logic [XLEN-1:0] cleared;
   logic [EW-1:0]   cur_b, below_b, pot_base, pot_size;

   // low run of ones, capped one bit short of the register width
   always_comb begin
      logic c;
      c   = 1'b1;
      run = '0;
      for (int i = 0; i < XLEN - 1; i++) begin
         c      = c & cur[i];
         run[i] = c;
      end
   end

   assign cleared  = cur & ~run;
   assign cur_b    = EW'({cur[XLEN-3:0], 2'b00});
   assign below_b  = EW'({below[XLEN-3:0], 2'b00});
   assign pot_base = EW'({cleared[XLEN-3:0], 2'b00});
   assign pot_size = (EW'(run) + EW'(1)) << 3;
   assign perm     = cfg_perm(cfg);

   always_comb begin
      en = 1'b1;
      lo = '0;
      hi = '0;
      unique case (cfg_mode(cfg))
         AM_TOR:   begin lo = below_b;  hi = cur_b;               end
         AM_NA4:   begin lo = cur_b;    hi = cur_b + EW'(4);      end
         AM_NAPOT: begin lo = pot_base; hi = pot_base + pot_size; end
         default:  en = 1'b0;
      endcase
   end

endmodule

// File: rtl/pmpc_span_match.sv
module pmpc_span_match #(
   parameter int EW = 35
) (
   input  logic [EW-1:0] reg_lo,
   input  logic [EW-1:0] reg_hi,
   input  logic [EW-1:0] acc_lo,
   input  logic [EW-1:0] acc_hi,
   output logic          hit,
   output logic [EW-1:0] cov
);
   logic [EW-1:0] top, bot;

   assign hit = (reg_lo < reg_hi) && (acc_lo < reg_hi) && (acc_hi > reg_lo);
   assign top = (acc_hi < reg_hi) ? acc_hi : reg_hi;
   assign bot = (acc_lo > reg_lo) ? acc_lo : reg_lo;
   assign cov = hit ? (top - bot) : '0;

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
   import pmpc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 16,
   localparam int IW = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic              csr_is_addr,
   input  logic [IW-1:0]     csr_num,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic [XLEN-1:0]   acc_addr,
   input  logic [XLEN-1:0]   acc_len,
   input  logic [PERM_W-1:0] acc_perm,
   output logic [1:0]        acc_verdict
);
   localparam int EW = XLEN + 3;
   localparam int SW = EW + IW;

   initial begin : param_checks
      assert (XLEN == 32 || XLEN == 64);
      assert (NREG >= 2 && (1 << IW) == NREG);
      assert (NREG % (XLEN / CFG_W) == 0);
   end

   logic [CFG_W-1:0]  cfg_q  [NREG];
   logic [XLEN-1:0]   addr_q [NREG];
   logic [NREG-1:0]   r_en, r_hit;
   logic [EW-1:0]     r_lo [NREG];
   logic [EW-1:0]     r_hi [NREG];
   logic [EW-1:0]     r_cov [NREG];
   logic [PERM_W-1:0] r_perm [NREG];
   logic [EW-1:0]     span_lo, span_hi;

   assign span_lo = EW'(acc_addr);
   assign span_hi = EW'(acc_addr) + EW'(acc_len);

   pmpc_csr_file #(.XLEN(XLEN), .NREG(NREG)) u_csr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (csr_we),
      .is_addr(csr_is_addr),
      .num    (csr_num),
      .wdata  (csr_wdata),
      .rdata  (csr_rdata),
      .cfg_o  (cfg_q),
      .addr_o (addr_q)
   );

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_region
         logic [XLEN-1:0] below;
         if (r == 0) begin : g_first
            assign below = '0;
         end else begin : g_rest
            assign below = addr_q[r-1];
         end

         pmpc_region_decode #(.XLEN(XLEN), .EW(EW)) u_dec (
            .cfg  (cfg_q[r]),
            .cur  (addr_q[r]),
            .below(below),
            .en   (r_en[r]),
            .lo   (r_lo[r]),
            .hi   (r_hi[r]),
            .perm (r_perm[r])
         );

         pmpc_span_match #(.EW(EW)) u_match (
            .reg_lo(r_lo[r]),
            .reg_hi(r_hi[r]),
            .acc_lo(span_lo),
            .acc_hi(span_hi),
            .hit   (r_hit[r]),
            .cov   (r_cov[r])
         );
      end
   endgenerate

   // ordered walk: a region counts only while coverage is short of the length
   always_comb begin
      logic [SW-1:0] cum;
      logic [SW-1:0] need;
      logic          deny;
      cum  = '0;
      deny = 1'b0;
      need = SW'(acc_len);
      for (int r = 0; r < NREG; r++) begin
         if (r_en[r] && r_hit[r] && cum < need) begin
            if ((r_perm[r] & acc_perm) != acc_perm) deny = 1'b1;
            else                                  cum  = cum + SW'(r_cov[r]);
         end
      end
      if (deny)              acc_verdict = VERD_DENY;
      else if (cum == '0)    acc_verdict = VERD_NONE;
      else if (cum >= need)  acc_verdict = VERD_FULL;
      else                   acc_verdict = VERD_DENY;
   end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
   import pmpc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 16,
   localparam int IW = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_we,
   input logic              csr_is_addr,
   input logic [IW-1:0]     csr_num,
   input logic [XLEN-1:0]   csr_wdata,
   input logic [XLEN-1:0]   csr_rdata,
   input logic [XLEN-1:0]   acc_len,
   input logic [1:0]        acc_verdict,
   input logic [CFG_W-1:0]  cfg [NREG]
);
   localparam int NWORD = NREG / (XLEN / CFG_W);

   logic all_off;
   always_comb begin
      all_off = 1'b1;
      for (int r = 0; r < NREG; r++) begin
         if (cfg_mode(cfg[r]) != AM_OFF) all_off = 1'b0;
      end
   end

   assert_verdict_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_verdict != 2'd3);

   assert_empty_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_len == '0 |-> acc_verdict == VERD_NONE);

   assert_all_off_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> acc_verdict == VERD_NONE);

   assert_addr_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(csr_we && csr_is_addr) && csr_is_addr && csr_num == $past(csr_num))
      |-> csr_rdata == $past(csr_wdata));

   assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (XLEN == 32 && $past(csr_we && !csr_is_addr) && !csr_is_addr &&
       csr_num == $past(csr_num) && int'(csr_num) < NWORD)
      |-> csr_rdata == $past(csr_wdata));

   assert_odd_word_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (XLEN == 64 && !csr_is_addr && csr_num[0]) |-> csr_rdata == '0);

endmodule

bind pmp_checker pmp_checker_sva #(.XLEN(XLEN), .NREG(NREG)) u_pmp_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .csr_we     (csr_we),
   .csr_is_addr(csr_is_addr),
   .csr_num    (csr_num),
   .csr_wdata  (csr_wdata),
   .csr_rdata  (csr_rdata),
   .acc_len    (acc_len),
   .acc_verdict(acc_verdict),
   .cfg        (cfg_q)
);

// File: tb/test_pmp_checker.sv
`timescale 1ns/1ps
module test_pmp_checker;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        csr_we = 0, csr_is_addr = 0;
   logic [3:0]  csr_num = 0;
   logic [31:0] csr_wdata = 0, csr_rdata;
   logic [31:0] acc_addr = 0, acc_len = 0;
   logic [2:0]  acc_perm = 0;
   logic [1:0]  acc_verdict;

   logic        w_we = 0, w_isa = 0;
   logic [3:0]  w_num = 0;
   logic [63:0] w_wdata = 0, w_rdata;
   logic [1:0]  w_verdict;

   pmp_checker #(.XLEN(32), .NREG(16)) i_pmp_checker (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_is_addr(csr_is_addr),
      .csr_num(csr_num), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .acc_addr(acc_addr), .acc_len(acc_len), .acc_perm(acc_perm),
      .acc_verdict(acc_verdict));

   pmp_checker #(.XLEN(64), .NREG(16)) i_pmp_checker_w64 (
      .clk(clk), .rst_n(rst_n), .csr_we(w_we), .csr_is_addr(w_isa),
      .csr_num(w_num), .csr_wdata(w_wdata), .csr_rdata(w_rdata),
      .acc_addr(64'd0), .acc_len(64'd0), .acc_perm(3'd0),
      .acc_verdict(w_verdict));

   int nvec = 0, nfail = 0;
   bit done = 0;

   // reference table: bounds and rights set alongside each register write
   bit     m_on [16];
   longint m_lo [16];
   longint m_hi [16];
   int     m_pm [16];

   localparam int NONE = 0, FULL = 1, DENY = 2;

   task automatic chk(input string tag, input longint act, input longint exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic csr_wr(input bit isa, input int num, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1; csr_is_addr = isa; csr_num = 4'(num); csr_wdata = d;
      @(negedge clk);
      csr_we = 0;
   endtask

   task automatic csr_rd(input bit isa, input int num, output logic [31:0] d);
      @(negedge clk);
      csr_is_addr = isa; csr_num = 4'(num);
      #1 d = csr_rdata;
   endtask

   task automatic w_wr(input int num, input logic [63:0] d);
      @(negedge clk);
      w_we = 1; w_isa = 0; w_num = 4'(num); w_wdata = d;
      @(negedge clk);
      w_we = 0;
   endtask

   task automatic w_rd(input int num, output logic [63:0] d);
      @(negedge clk);
      w_isa = 0; w_num = 4'(num);
      #1 d = w_rdata;
   endtask

   task automatic probe(input longint a, input longint l, input int p, output int v);
      @(negedge clk);
      acc_addr = 32'(a); acc_len = 32'(l); acc_perm = 3'(p);
      #1 v = int'(acc_verdict);
   endtask

   function automatic int model(longint a, longint l, int p);
      longint cov = 0;
      longint e = a + l;
      for (int i = 0; i < 16; i++) begin
         if (cov >= l) break;
         if (!m_on[i]) continue;
         if (m_lo[i] < m_hi[i] && a < m_hi[i] && e > m_lo[i]) begin
            if ((m_pm[i] & p) != p) return DENY;
            cov += ((e < m_hi[i]) ? e : m_hi[i]) - ((a > m_lo[i]) ? a : m_lo[i]);
         end
      end
      if (cov == 0) return NONE;
      if (cov >= l) return FULL;
      return DENY;
   endfunction

   task automatic sweep(input longint start, input int steps, input int stride);
      int lens [7] = '{0, 1, 3, 4, 8, 16, 64};
      int v;
      for (int s = 0; s < steps; s++) begin
         for (int li = 0; li < 7; li++) begin
            for (int p = 1; p < 8; p++) begin
               longint a = start + longint'(s * stride);
               probe(a, lens[li], p, v);
               chk("R9 sweep", v, model(a, lens[li], p));
            end
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin : stimulus
      logic [31:0] d;
      logic [63:0] dw;
      int v;
      for (int i = 0; i < 16; i++) begin
         m_on[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_pm[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      for (int n = 0; n < 4; n++) begin
         csr_rd(0, n, d); chk("R1 cfg word", d, 0);
      end
      for (int n = 0; n < 16; n++) begin
         csr_rd(1, n, d); chk("R1 addr reg", d, 0);
      end
      probe(32'h100, 4, 1, v); chk("R1 verdict", v, NONE);

      // region programming
      csr_wr(1, 0, 32'h40);  m_on[0] = 1; m_lo[0] = 'h100; m_hi[0] = 'h104; m_pm[0] = 1;
      csr_wr(1, 1, 32'h48);  m_on[1] = 1; m_lo[1] = 'h100; m_hi[1] = 'h120; m_pm[1] = 3;
      csr_wr(1, 2, 32'h47);  m_on[2] = 1; m_lo[2] = 'h100; m_hi[2] = 'h140; m_pm[2] = 4;
      csr_wr(1, 3, 32'h6A);
      csr_wr(1, 4, 32'h60);
      csr_wr(1, 5, 32'h64);  m_on[5] = 1; m_lo[5] = 'h180; m_hi[5] = 'h190; m_pm[5] = 7;
      csr_wr(1, 6, 32'h50);  m_on[6] = 1; m_lo[6] = 'h190; m_hi[6] = 'h140; m_pm[6] = 7;
      csr_wr(1, 8, 32'h0400_01FF);
      m_on[8] = 1; m_lo[8] = 'h1000_0000; m_hi[8] = 'h1000_1000; m_pm[8] = 3;
      csr_wr(1, 15, 32'h68); m_on[15] = 1; m_lo[15] = 'h1A0; m_hi[15] = 'h1A4; m_pm[15] = 1;
      csr_wr(0, 0, 32'h071C_0B11);
      csr_wr(0, 1, 32'h000F_0F00);
      csr_wr(0, 2, 32'h0000_001B);
      csr_wr(0, 3, 32'h1100_0000);

      csr_rd(0, 0, d); chk("R2 word0", d, 32'h071C_0B11);
      csr_rd(0, 3, d); chk("R2 word3", d, 32'h1100_0000);
      csr_rd(1, 2, d); chk("R4 addr2", d, 32'h47);
      csr_rd(1, 8, d); chk("R4 addr8", d, 32'h0400_01FF);

      // R3 wide packing on the second instance
      w_wr(2, 64'h1122_3344_5566_7788);
      w_rd(2, dw); chk("R3 word2", dw, 64'h1122_3344_5566_7788);
      w_wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
      w_rd(1, dw); chk("R3 odd word", dw, 0);
      w_rd(0, dw); chk("R3 word0 untouched", dw, 0);

      probe(32'h1A8, 4, 7, v);     chk("R5 off region", v, NONE);
      probe(32'h184, 4, 7, v);     chk("R6 range", v, FULL);
      probe(32'h140, 8, 7, v);     chk("R6 inverted range", v, NONE);
      probe(32'h1A0, 4, 1, v);     chk("R7 slot", v, FULL);
      probe(32'h1A2, 4, 1, v);     chk("R7 partial", v, DENY);
      probe(32'h1000_0FFC, 4, 1, v); chk("R8 block end", v, FULL);
      probe(32'h1000_0FFE, 4, 1, v); chk("R8 past end", v, DENY);
      probe(32'h0FFF_FFFE, 2, 1, v); chk("R8 below base", v, NONE);
      probe(32'h1A4, 4, 1, v);     chk("R9 exclusive end", v, NONE);
      probe(32'h104, 4, 2, v);     chk("R9 next byte", v, FULL);
      probe(32'h100, 4, 2, v);     chk("R10 write denied", v, DENY);
      probe(32'h13C, 8, 4, v);     chk("R11 partial", v, DENY);
      probe(32'h200, 8, 1, v);     chk("R11 uncovered", v, NONE);
      probe(32'h100, 0, 1, v);     chk("R11 zero length", v, NONE);
      probe(32'h100, 4, 1, v);     chk("R12 early stop", v, FULL);

      sweep('hF0, 97, 2);
      sweep('h0FFF_FFF0, 16, 2);
      sweep('h1000_0FF0, 16, 2);

      // whole address space region
      csr_wr(1, 7, 32'hFFFF_FFFF);
      csr_wr(0, 1, 32'h1F0F_0F00);
      m_on[7] = 1; m_lo[7] = 0; m_hi[7] = longint'(1) << 34; m_pm[7] = 7;
      probe(32'hFFFF_FFF0, 16, 7, v); chk("R8 whole space", v, FULL);
      probe(32'h120, 4, 1, v);        chk("R12 earlier deny wins", v, DENY);
      sweep('hF0, 97, 2);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule